// File: doc/BRIEF.md
# Two-Section Biquad Transmit Filter

This block shapes the digital transmit stream before it reaches the converter. Two second-order IIR sections sit in series, and each one computes y = (B0·x + B1·x[-1] + B2·x[-2] − A1·y[-1] − A2·y[-2]) in fixed point. The coefficients are 16-bit two's-complement numbers with 13 fractional bits, so 8192 stands for 1.0 and the usable range is about ±4. A 10-bit signed sample enters with a valid strobe. The filtered 10-bit sample leaves a fixed number of clock cycles later, also with a strobe.

A synchronous write port holds all ten coefficients and one enable bit per section. After reset every register holds a working lowpass setting. A section whose enable is cleared passes its input through unchanged, with the same latency as when it filters. Each section saturates its own output to the internal word before the next section uses it, and the last result is saturated to 10 bits.

Top module: `txf_biquad_cascade`

## Requirements
- R1: After reset both enables are 1. Section 0 holds B0=0x0825, B1=0xF43A, B2=0x0825, A1=0xCEFF, A2=0x1613. Section 1 holds B0=0x1DAA, B1=0xCBEF, B2=0x1DAA, A1=0xC7F6, A2=0x1F4D. `out_valid` is 0 and `out_sample` is 0.
- R2: A cycle with `wr_en` high writes `wr_data` on the next edge. `wr_addr[3]` selects the section. `wr_addr[2:0]` selects the field: 0=B0, 1=B1, 2=B2, 3=A1, 4=A2, 5=enable (taken from `wr_data[0]`).
- R3: An enabled section forms the exact sum B0·x + B1·x1 + B2·x2 − A1·y1 − A2·y2 from its two previous inputs and its two previous outputs. It then adds 4096 and shifts arithmetically right by 13.
- R4: Each section's output saturates to the signed 16-bit range. The stored output history holds the saturated value.
- R5: The final output saturates to the signed 10-bit range [−512, 511].
- R6: A section with enable 0 outputs its input value unchanged, with the same one-cycle latency.
- R7: The history of a section is zero after reset. It is cleared whenever its enable changes value, and it is held at zero while the section is disabled. Rewriting the current enable value leaves the history intact.
- R8: `out_valid` is high exactly two cycles after each cycle with `in_valid` high. Samples presented with `in_valid` low change neither the output nor any filter state.
- R9: Writes to field codes 6 and 7 have no effect on any coefficient or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 10 | Input sample, signed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Section select (bit 3) and field code (bits 2:0) |
| wr_data | input | 16 | Coefficient value or enable bit |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 10 | Filtered sample, signed, saturated |

## Verification
The assertions assume that every input is a known value at each rising edge after reset. They also assume that `in_valid` is low while reset is held, because the valid-chain properties start from the first active cycle. The bypass and history-clear properties judge a section against the enable value the register bank shows in the same cycle, so they take it for granted that enable writes only reach the datapath through that bank. The bench drives every input on the falling edge and keeps `in_valid` low throughout reset. Writes and samples go in separate cycles, so the order in which they take effect is fixed.

// File: rtl/txf_pkg.sv
package txf_pkg;

  localparam int NSEC    = 2;
  localparam int NTAP    = 5;
  localparam int FIELD_W = 3;
  localparam int SEL_W   = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int ADDR_W  = SEL_W + FIELD_W;

  // field codes inside one section's address window
  localparam int IDX_B0 = 0;
  localparam int IDX_B1 = 1;
  localparam int IDX_B2 = 2;
  localparam int IDX_A1 = 3;
  localparam int IDX_A2 = 4;
  localparam int IDX_EN = 5;

  // reset coefficient table, Q13 in 16-bit words
  function automatic logic [15:0] dflt_coef(input int sec, input int tap);
    logic [15:0] v;
    v = 16'h0000;
    if (sec == 0) begin
      case (tap)
        IDX_B0:  v = 16'h0825;
        IDX_B1:  v = 16'hF43A;
        IDX_B2:  v = 16'h0825;
        IDX_A1:  v = 16'hCEFF;
        IDX_A2:  v = 16'h1613;
        default: v = 16'h0000;
      endcase
    end else begin
      case (tap)
        IDX_B0:  v = 16'h1DAA;
        IDX_B1:  v = 16'hCBEF;
        IDX_B2:  v = 16'h1DAA;
        IDX_A1:  v = 16'hC7F6;
        IDX_A2:  v = 16'h1F4D;
        default: v = 16'h0000;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/txf_coef_bank.sv
module txf_coef_bank
  import txf_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [COEF_W-1:0]                   wr_data,
  output logic [NSEC-1:0][NTAP-1:0][COEF_W-1:0] coefs,
  output logic [NSEC-1:0]                     sec_en
);

  logic [SEL_W-1:0]   wsel;
  logic [FIELD_W-1:0] wfld;

  assign wsel = wr_addr[ADDR_W-1:FIELD_W];
  assign wfld = wr_addr[FIELD_W-1:0];

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic hit;
    assign hit = wr_en && (int'(wsel) == s);

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          coefs[s][t] <= COEF_W'(dflt_coef(s, t));
        else if (hit && (int'(wfld) == t))
          coefs[s][t] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sec_en[s] <= 1'b1;
      else if (hit && (int'(wfld) == IDX_EN))
        sec_en[s] <= wr_data[0];
    end
  end

endmodule

// File: rtl/txf_biquad_sec.sv
module txf_biquad_sec
  import txf_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [NTAP-1:0][COEF_W-1:0]  coefs,
  input  logic                         in_vld,
  input  logic [INT_W-1:0]             in_x,
  output logic                         out_vld,
  output logic [INT_W-1:0]             out_y,
  output logic                         hist_zero
);

  localparam int ACC_W = INT_W + COEF_W + 3;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (INT_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  // one product widened to the accumulator
  function automatic logic signed [ACC_W-1:0] prod(input logic [COEF_W-1:0] c,
                                                   input logic [INT_W-1:0]  v);
    return ACC_W'($signed(c)) * ACC_W'($signed(v));
  endfunction

  // round to nearest (ties upward), drop fraction, clamp to INT_W
  function automatic logic [INT_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = (a + HALF) >>> FRAC_W;
    if (r > MAXV) r = MAXV;
    else if (r < MINV) r = MINV;
    return r[INT_W-1:0];
  endfunction

  logic                     en_q;
  logic                     flush;
  logic [INT_W-1:0]         x1, x2, y1, y2;
  logic [INT_W-1:0]         hx1, hx2, hy1, hy2;
  logic signed [ACC_W-1:0]  acc;
  logic [INT_W-1:0]         y_new;

  // history is forgotten on an enable edge and while bypassed
  assign flush = (en != en_q) || !en;

  assign hx1 = flush ? '0 : x1;
  assign hx2 = flush ? '0 : x2;
  assign hy1 = flush ? '0 : y1;
  assign hy2 = flush ? '0 : y2;

  always_comb begin
    acc = prod(coefs[IDX_B0], in_x)
        + prod(coefs[IDX_B1], hx1)
        + prod(coefs[IDX_B2], hx2)
        - prod(coefs[IDX_A1], hy1)
        - prod(coefs[IDX_A2], hy2);
    y_new = round_sat(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      out_vld <= 1'b0;
      out_y   <= '0;
      x1      <= '0;
      x2      <= '0;
      y1      <= '0;
      y2      <= '0;
    end else begin
      en_q    <= en;
      out_vld <= in_vld;
      if (flush) begin
        x1 <= '0;
        x2 <= '0;
        y1 <= '0;
        y2 <= '0;
      end
      if (in_vld) begin
        out_y <= en ? y_new : in_x;
        if (en) begin
          x1 <= in_x;
          x2 <= hx1;
          y1 <= y_new;
          y2 <= hy1;
        end
      end
    end
  end

  assign hist_zero = (x1 == '0) && (x2 == '0) && (y1 == '0) && (y2 == '0);

endmodule

// File: rtl/txf_biquad_cascade.sv
module txf_biquad_cascade
  import txf_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int INT_W  = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);

  localparam logic signed [INT_W-1:0] OMAX = INT_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [INT_W-1:0] OMIN = -OMAX - INT_W'(1);

  function automatic logic [DATA_W-1:0] clamp_out(input logic [INT_W-1:0] v);
    logic signed [INT_W-1:0] s;
    s = $signed(v);
    if (s > OMAX) s = OMAX;
    else if (s < OMIN) s = OMIN;
    return s[DATA_W-1:0];
  endfunction

  logic [NSEC-1:0][NTAP-1:0][COEF_W-1:0] coefs;
  logic [NSEC-1:0]                     sec_en;
  logic [NSEC-1:0]                     stg_vld;
  logic [NSEC-1:0][INT_W-1:0]          stg_y;
  logic [NSEC-1:0]                     hist_zero;

  txf_coef_bank #(.COEF_W(COEF_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .coefs   (coefs),
    .sec_en  (sec_en)
  );

  for (genvar k = 0; k < NSEC; k++) begin : g_stage
    logic             s_vld;
    logic [INT_W-1:0] s_x;

    if (k == 0) begin : g_head
      assign s_vld = in_valid;
      assign s_x   = {{(INT_W-DATA_W){in_sample[DATA_W-1]}}, in_sample};
    end else begin : g_link
      assign s_vld = stg_vld[k-1];
      assign s_x   = stg_y[k-1];
    end

    txf_biquad_sec #(
      .INT_W  (INT_W),
      .COEF_W (COEF_W),
      .FRAC_W (FRAC_W)
    ) i_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (sec_en[k]),
      .coefs     (coefs[k]),
      .in_vld    (s_vld),
      .in_x      (s_x),
      .out_vld   (stg_vld[k]),
      .out_y     (stg_y[k]),
      .hist_zero (hist_zero[k])
    );
  end

  assign out_valid  = stg_vld[NSEC-1];
  assign out_sample = clamp_out(stg_y[NSEC-1]);

endmodule

// File: rtl/txf_cascade_chk.sv
module txf_cascade_chk
  import txf_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int INT_W  = 16,
  parameter int COEF_W = 16
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                in_valid,
  input logic [DATA_W-1:0]                   in_sample,
  input logic                                wr_en,
  input logic [NSEC-1:0][NTAP-1:0][COEF_W-1:0] coefs,
  input logic [NSEC-1:0]                     sec_en,
  input logic [NSEC-1:0]                     stg_vld,
  input logic [NSEC-1:0][INT_W-1:0]          stg_y,
  input logic [NSEC-1:0]                     hist_zero
);

  logic [INT_W-1:0] in_ext;
  assign in_ext = {{(INT_W-DATA_W){in_sample[DATA_W-1]}}, in_sample};

  // R8
  head_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> stg_vld[0]);

  // R8
  head_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !stg_vld[0]);

  for (genvar k = 1; k < NSEC; k++) begin : g_chain
    // R8
    link_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg_vld[k-1] |=> stg_vld[k]);
  end

  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sec_en[0]) |=> (stg_y[0] == $past(in_ext)));

  for (genvar k = 0; k < NSEC; k++) begin : g_hist
    // R7
    hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_en[k] |=> hist_zero[k]);
  end

  // R2
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(coefs) && $stable(sec_en)));

endmodule

bind txf_biquad_cascade txf_cascade_chk #(
  .DATA_W (DATA_W),
  .INT_W  (INT_W),
  .COEF_W (COEF_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .wr_en     (wr_en),
  .coefs     (coefs),
  .sec_en    (sec_en),
  .stg_vld   (stg_vld),
  .stg_y     (stg_y),
  .hist_zero (hist_zero)
);

// File: tb/test_txf_biquad_cascade.sv
module test_txf_biquad_cascade;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [9:0]  in_sample = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        out_valid;
  logic [9:0]  out_sample;

  always #10 clk = ~clk;

  txf_biquad_cascade i_txf_biquad_cascade (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  int    checks = 0;
  int    errors = 0;
  string req = "R1";
  bit    done = 1'b0;

  // behavioural reference: coefficients, enables, history
  longint mc [2][5];
  bit     men [2];
  longint mx1 [2], mx2 [2], my1 [2], my2 [2];
  bit         pv_v [2];
  logic [9:0] pv_d [2];

  function automatic longint msat(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint c16(logic [15:0] d);
    return longint'($signed(d));
  endfunction

  function automatic void mclear(int s);
    mx1[s] = 0; mx2[s] = 0; my1[s] = 0; my2[s] = 0;
  endfunction

  function automatic void mdefaults();
    mc[0][0] = c16(16'h0825); mc[0][1] = c16(16'hF43A); mc[0][2] = c16(16'h0825);
    mc[0][3] = c16(16'hCEFF); mc[0][4] = c16(16'h1613);
    mc[1][0] = c16(16'h1DAA); mc[1][1] = c16(16'hCBEF); mc[1][2] = c16(16'h1DAA);
    mc[1][3] = c16(16'hC7F6); mc[1][4] = c16(16'h1F4D);
    men[0] = 1'b1; men[1] = 1'b1;
    mclear(0); mclear(1);
  endfunction

  function automatic longint mstep(int s, longint x);
    longint acc, y;
    if (!men[s]) return x;
    acc = mc[s][0] * x + mc[s][1] * mx1[s] + mc[s][2] * mx2[s]
        - mc[s][3] * my1[s] - mc[s][4] * my2[s];
    y = msat((acc + 4096) >>> 13, 16);
    mx2[s] = mx1[s]; mx1[s] = x;
    my2[s] = my1[s]; my1[s] = y;
    return y;
  endfunction

  function automatic void mwrite(logic [3:0] a, logic [15:0] d);
    int s = int'(a[3]);
    int f = int'(a[2:0]);
    if (f < 5) mc[s][f] = c16(d);
    else if (f == 5) begin
      if (d[0] != men[s]) mclear(s);
      men[s] = d[0];
    end
  endfunction

  // one clock: compare, then drive, then advance the model
  task automatic tick(bit v, logic [9:0] x, bit w, logic [3:0] a, logic [15:0] d);
    longint y;
    @(negedge clk);
    checks++;
    if (out_valid !== pv_v[1] || (pv_v[1] && out_sample !== pv_d[1])) begin
      errors++;
      $display("FAIL %s: actual valid=%0b sample=%0d expected valid=%0b sample=%0d",
               req, out_valid, $signed(out_sample), pv_v[1], $signed(pv_d[1]));
    end
    in_valid = v; in_sample = x; wr_en = w; wr_addr = a; wr_data = d;
    pv_v[1] = pv_v[0]; pv_d[1] = pv_d[0];
    pv_v[0] = v;
    if (v) begin
      y = mstep(0, longint'($signed(x)));
      y = mstep(1, y);
      pv_d[0] = 10'(msat(y, 10));
    end
    if (w) mwrite(a, d);
  endtask

  task automatic smp(logic [9:0] x);
    tick(1'b1, x, 1'b0, 4'h0, 16'h0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 10'h2AA, 1'b0, 4'h0, 16'h0);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    tick(1'b0, 10'h0, 1'b1, a, d);
  endtask

  task automatic restore_defaults();
    wr(4'h0, 16'h0825); wr(4'h1, 16'hF43A); wr(4'h2, 16'h0825);
    wr(4'h3, 16'hCEFF); wr(4'h4, 16'h1613);
    wr(4'h8, 16'h1DAA); wr(4'h9, 16'hCBEF); wr(4'hA, 16'h1DAA);
    wr(4'hB, 16'hC7F6); wr(4'hC, 16'h1F4D);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    mdefaults();
    pv_v[0] = 1'b0; pv_v[1] = 1'b0; pv_d[0] = '0; pv_d[1] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state, R8 no valid during reset
    checks++;
    if (out_valid !== 1'b0 || out_sample !== 10'd0) begin
      errors++;
      $display("FAIL R1: reset actual valid=%0b sample=%0d expected valid=0 sample=0",
               out_valid, $signed(out_sample));
    end
    rst_n = 1'b1;

    req = "R1";  // impulse through the reset coefficients
    smp(10'sd200); idle(40);

    req = "R8";  // gapped samples, garbage on invalid cycles
    for (int i = 0; i < 20; i++) begin
      smp(10'(i * 23 - 200));
      tick(1'b0, 10'h155, 1'b0, 4'h0, 16'h0);
    end
    idle(10);

    req = "R3";  // dense pseudo-random stream
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      smp(lfsr[9:0]);
    end
    idle(30);

    req = "R9";  // unused field codes
    wr(4'h6, 16'h1234); wr(4'hF, 16'hFFFF); wr(4'h7, 16'h0000); wr(4'hE, 16'h0000);
    smp(10'sd100); idle(30);

    req = "R2";  // section 0 = 1.0, section 1 = 2.0
    wr(4'h0, 16'h2000); wr(4'h1, 16'h0); wr(4'h2, 16'h0); wr(4'h3, 16'h0); wr(4'h4, 16'h0);
    wr(4'h8, 16'h4000); wr(4'h9, 16'h0); wr(4'hA, 16'h0); wr(4'hB, 16'h0); wr(4'hC, 16'h0);
    idle(3);
    smp(10'sd100); smp(-10'sd77); idle(4);
    req = "R5";  // doubled values beyond 10-bit range
    smp(10'sd300); smp(-10'sd300); smp(10'sd256); smp(-10'sd256); idle(4);

    req = "R4";  // integrator in section 0 runs into its 16-bit limit
    wr(4'h3, 16'hE000);
    wr(4'h8, 16'h0040);
    idle(2);
    for (int i = 0; i < 80; i++) smp(10'sd511);
    for (int i = 0; i < 20; i++) smp(-10'sd512);
    idle(4);

    req = "R6";  // bypass section 0, then both
    wr(4'h5, 16'h0000);
    smp(10'sd123); smp(-10'sd45); smp(10'sd7); idle(4);
    wr(4'hD, 16'h0000);
    smp(-10'sd512); smp(10'sd511); smp(10'sd7); smp(10'sd0); idle(4);

    req = "R7";  // re-enable with reset coefficients, history starts clean
    restore_defaults();
    wr(4'h5, 16'h0001); wr(4'hD, 16'h0001);
    smp(10'sd200); idle(40);
    for (int i = 0; i < 20; i++) smp(10'(i * 31 - 300));
    wr(4'hD, 16'h0001);  // same value: history kept
    for (int i = 0; i < 10; i++) smp(10'sd50);
    wr(4'h5, 16'h0000); wr(4'h5, 16'h0001);  // toggle: history cleared
    smp(10'sd200); idle(40);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule